// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits between two independent ports that share a memory map and lets each port signal the other. The top two addresses of a 12-bit space are reserved as mailboxes. When one port writes the other port's mailbox, the receiving port gets an active-low interrupt. The message word stays in that location. When the receiving port reads the location, it gets the word back and its interrupt is cleared. No dedicated control registers exist: ordinary memory cycles set and clear the flags as a side effect.

The model is clocked. On each rising clock edge every port presents one access: a write, a read or nothing. Both interrupt outputs are registered. Read data appears on the cycle after the read. The rest of the RAM array and any busy arbitration sit outside this block.

Top module: `mailbox_irq`

## Requirements
- R1: After reset, int_l_n and int_r_n are high, both mailbox words are zero, and both read-data outputs are zero.
- R2: A port performs a write in a cycle with ce_n low and rw low, whatever oe_n is. It performs a read in a cycle with ce_n low, rw high and oe_n low. Any other cycle is no access.
- R3: A write by the left port to address 0xFFF drives int_r_n low from the next cycle.
- R4: A read by the right port of 0xFFF, with no left write to 0xFFF in the same cycle, drives int_r_n high from the next cycle.
- R5: A write by the right port to address 0xFFE drives int_l_n low from the next cycle.
- R6: A read by the left port of 0xFFE, with no right write to 0xFFE in the same cycle, drives int_l_n high from the next cycle.
- R7: When an interrupt's set and its clear fall in the same cycle, the set wins and the interrupt is low on the next cycle.
- R8: A port that writes its own receive mailbox (the right port writing 0xFFF, or the left port writing 0xFFE) stores the word but leaves both interrupts unchanged.
- R9: In the cycle after a read of 0xFFF or 0xFFE, the port's rdata holds that location's word as it was before any write in the read cycle. In every other cycle rdata is zero.
- R10: When both ports write the same mailbox in one cycle, the left port's word is stored.
- R11: Accesses to any address other than 0xFFF and 0xFFE leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | 12 | Left port address |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left read data, one cycle after the read |
| r_addr | input | 12 | Right port address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right read data, one cycle after the read |
| int_l_n | output | 1 | Interrupt toward the left port, active low |
| int_r_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The hardest case to produce is a set and a clear of the same flag in one cycle. This needs a write from one port and a read of the same address from the other port on the same edge. The bench sets up both ports in one step so that they hit the same edge. It then checks that the flag stays asserted and that the reader got the old word. A second read then returns the new word and clears the flag.

// File: rtl/mailbox_irq.sv
module mailbox_irq #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_ce_n,
  input  logic          l_oe_n,
  input  logic          l_rw,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic [AW-1:0] r_addr,
  input  logic          r_ce_n,
  input  logic          r_oe_n,
  input  logic          r_rw,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          int_l_n,
  output logic          int_r_n
);
  localparam logic [AW-1:0] BOX_TO_R = '1;
  localparam logic [AW-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

  logic l_wr, l_rd, r_wr, r_rd;
  logic [DW-1:0] word_to_r, word_to_l;
  logic flag_r, flag_l;

  assign l_wr = !l_ce_n && !l_rw;
  assign l_rd = !l_ce_n && l_rw && !l_oe_n;
  assign r_wr = !r_ce_n && !r_rw;
  assign r_rd = !r_ce_n && r_rw && !r_oe_n;

  logic set_r, clr_r, set_l, clr_l;
  assign set_r = l_wr && (l_addr == BOX_TO_R);
  assign clr_r = r_rd && (r_addr == BOX_TO_R);
  assign set_l = r_wr && (r_addr == BOX_TO_L);
  assign clr_l = l_rd && (l_addr == BOX_TO_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_to_r <= '0;
      word_to_l <= '0;
    end else begin
      if (l_wr && l_addr == BOX_TO_R)      word_to_r <= l_wdata;
      else if (r_wr && r_addr == BOX_TO_R) word_to_r <= r_wdata;
      if (l_wr && l_addr == BOX_TO_L)      word_to_l <= l_wdata;
      else if (r_wr && r_addr == BOX_TO_L) word_to_l <= r_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r <= 1'b0;
      flag_l <= 1'b0;
    end else begin
      if (set_r)      flag_r <= 1'b1;
      else if (clr_r) flag_r <= 1'b0;
      if (set_l)      flag_l <= 1'b1;
      else if (clr_l) flag_l <= 1'b0;
    end
  end

  function automatic logic [DW-1:0] pick(input logic rd, input logic [AW-1:0] a,
                                         input logic [DW-1:0] wr_word, input logic [DW-1:0] wl_word);
    if (!rd)                 return '0;
    else if (a == BOX_TO_R)  return wr_word;
    else if (a == BOX_TO_L)  return wl_word;
    else                     return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      l_rdata <= pick(l_rd, l_addr, word_to_r, word_to_l);
      r_rdata <= pick(r_rd, r_addr, word_to_r, word_to_l);
    end
  end

  assign int_r_n = !flag_r;
  assign int_l_n = !flag_l;

  assert_set_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_rw && l_addr == BOX_TO_R) |=> !int_r_n);
  assert_clr_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && r_rw && !r_oe_n && r_addr == BOX_TO_R &&
     !(!l_ce_n && !l_rw && l_addr == BOX_TO_R)) |=> int_r_n);
  assert_set_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_rw && r_addr == BOX_TO_L) |=> !int_l_n);
  assert_clr_l_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_rw && !l_oe_n && l_addr == BOX_TO_L &&
     !(!r_ce_n && !r_rw && r_addr == BOX_TO_L)) |=> int_l_n);
  assert_own_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_rw && r_addr == BOX_TO_R && !(!l_ce_n && !l_rw && l_addr == BOX_TO_R))
    |=> $stable(int_r_n));
  assert_own_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_rw && l_addr == BOX_TO_L && !(!r_ce_n && !r_rw && r_addr == BOX_TO_L))
    |=> $stable(int_l_n));
  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce_n || !l_rw || l_oe_n) |=> (l_rdata == '0));
endmodule

// File: tb/tb_mailbox_irq.sv
module tb_mailbox_irq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_ce_n = 1'b1, l_oe_n = 1'b1, l_rw = 1'b1;
  logic r_ce_n = 1'b1, r_oe_n = 1'b1, r_rw = 1'b1;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic int_l_n, int_r_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mailbox_irq #(.AW(AW), .DW(DW)) dut (
    .clk, .rst_n,
    .l_addr, .l_ce_n, .l_oe_n, .l_rw, .l_wdata, .l_rdata,
    .r_addr, .r_ce_n, .r_oe_n, .r_rw, .r_wdata, .r_rdata,
    .int_l_n, .int_r_n
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    l_ce_n = 1; l_oe_n = 1; l_rw = 1;
    r_ce_n = 1; r_oe_n = 1; r_rw = 1;
  endtask

  task automatic lset(input logic ce_n, input logic oe_n, input logic rw,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce_n = ce_n; l_oe_n = oe_n; l_rw = rw; l_addr = a; l_wdata = d;
  endtask

  task automatic rset(input logic ce_n, input logic oe_n, input logic rw,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce_n = ce_n; r_oe_n = oe_n; r_rw = rw; r_addr = a; r_wdata = d;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1", "int_l_n", int_l_n, 1);
    chk("R1", "int_r_n", int_r_n, 1);
    chk("R1", "l_rdata", l_rdata, 0);
    lset(0, 0, 1, 12'hFFF, 0); rset(0, 0, 1, 12'hFFE, 0); tick(); idle();
    chk("R1", "word FFF after reset", l_rdata, 0);
    chk("R1", "word FFE after reset", r_rdata, 0);
  endtask

  task automatic t_left_to_right();
    lset(0, 1, 0, 12'hFFF, 9'h1A5); tick(); idle();
    chk("R3", "int_r_n after left write", int_r_n, 0);
    chk("R3", "int_l_n untouched", int_l_n, 1);
    tick();
    chk("R3", "int_r_n held", int_r_n, 0);
    rset(0, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R4", "int_r_n after right read", int_r_n, 1);
    chk("R9", "r_rdata", r_rdata, 9'h1A5);
    tick();
    chk("R9", "r_rdata back to zero", r_rdata, 0);
  endtask

  task automatic t_right_to_left();
    rset(0, 1, 0, 12'hFFE, 9'h0C3); tick(); idle();
    chk("R5", "int_l_n after right write", int_l_n, 0);
    chk("R5", "int_r_n untouched", int_r_n, 1);
    lset(0, 0, 1, 12'hFFE, 0); tick(); idle();
    chk("R6", "int_l_n after left read", int_l_n, 1);
    chk("R9", "l_rdata", l_rdata, 9'h0C3);
  endtask

  task automatic t_encoding();
    lset(1, 0, 0, 12'hFFF, 9'h055); tick(); idle();
    chk("R2", "write with ce_n high", int_r_n, 1);
    lset(0, 0, 0, 12'hFFF, 9'h066); tick(); idle();
    chk("R2", "write with oe_n low", int_r_n, 0);
    rset(0, 1, 1, 12'hFFF, 0); tick(); idle();
    chk("R2", "read with oe_n high keeps int", int_r_n, 0);
    chk("R2", "read with oe_n high rdata", r_rdata, 0);
    rset(1, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R2", "read with ce_n high keeps int", int_r_n, 0);
    rset(0, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R2", "proper read clears", int_r_n, 1);
    chk("R2", "word from oe_n-low write", r_rdata, 9'h066);
  endtask

  task automatic t_set_wins();
    lset(0, 1, 0, 12'hFFF, 9'h0AA); rset(0, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R7", "int_r_n set wins", int_r_n, 0);
    chk("R9", "reader sees old word", r_rdata, 9'h066);
    rset(0, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R7", "later read clears", int_r_n, 1);
    chk("R7", "later read new word", r_rdata, 9'h0AA);
    rset(0, 1, 0, 12'hFFE, 9'h0BB); lset(0, 0, 1, 12'hFFE, 0); tick(); idle();
    chk("R7", "int_l_n set wins", int_l_n, 0);
    lset(0, 0, 1, 12'hFFE, 0); tick(); idle();
    chk("R7", "int_l_n cleared later", int_l_n, 1);
  endtask

  task automatic t_own();
    rset(0, 1, 0, 12'hFFF, 9'h0F0); tick(); idle();
    chk("R8", "right own write int_r_n", int_r_n, 1);
    chk("R8", "right own write int_l_n", int_l_n, 1);
    lset(0, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R8", "word stored by own write", l_rdata, 9'h0F0);
    lset(0, 1, 0, 12'hFFE, 9'h00F); tick(); idle();
    chk("R8", "left own write int_l_n", int_l_n, 1);
    chk("R8", "left own write int_r_n", int_r_n, 1);
    rset(0, 0, 1, 12'hFFE, 0); tick(); idle();
    chk("R8", "left own word stored", r_rdata, 9'h00F);
  endtask

  task automatic t_collide();
    lset(0, 1, 0, 12'hFFE, 9'h111); rset(0, 1, 0, 12'hFFE, 9'h122); tick(); idle();
    chk("R10", "int_l_n set by right write", int_l_n, 0);
    chk("R10", "int_r_n untouched", int_r_n, 1);
    lset(0, 0, 1, 12'hFFE, 0); tick(); idle();
    chk("R10", "left word kept", l_rdata, 9'h111);
    chk("R10", "int_l_n cleared", int_l_n, 1);
  endtask

  task automatic t_other();
    lset(0, 1, 0, 12'h123, 9'h1FF); rset(0, 1, 0, 12'hFFD, 9'h1FF); tick(); idle();
    chk("R11", "int_r_n other addr", int_r_n, 1);
    chk("R11", "int_l_n other addr", int_l_n, 1);
    lset(0, 1, 0, 12'hFFF, 9'h077); tick(); idle();
    rset(0, 0, 1, 12'h7FF, 0); tick(); idle();
    chk("R11", "read elsewhere keeps int_r_n", int_r_n, 0);
    chk("R9", "read elsewhere rdata zero", r_rdata, 0);
    rset(0, 0, 1, 12'hFFF, 0); tick(); idle();
    chk("R11", "cleanup clears", int_r_n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_left_to_right();
    t_right_to_left();
    t_encoding();
    t_set_wins();
    t_own();
    t_collide();
    t_other();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule